// File: doc/BRIEF.md
# Farrow Cubic Fractional-Delay Interpolator

This block resamples a complex baseband stream by a fractional sample delay that may change on every sample. A receiver uses it to correct sampling clock offset while its converter runs from a free clock. Each output is built from the four most recent accepted samples. Four fixed sub-filters run on that sample history. Their outputs are then combined by a Horner evaluation in the fractional delay d. The effective 4-tap coefficients are cubic polynomials in d. They are never looked up or recomputed. The sub-filters implement cubic Lagrange interpolation, with the constants stored in fixed point.

Samples enter and leave on valid/ready streams. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. The pipeline moves as one unit. While `out_valid` is high and `out_ready` is low, every stage holds, the output stays stable and `in_ready` is low. The producer must then keep its beat presented. Choosing d, skipping or repeating whole samples, and designing the coefficients are all left to the surrounding logic.

Top module: `farrow_interp`

## Requirements
- R1: An active-low asynchronous reset clears `out_valid` and the sample history. After reset, `in_ready` is high, and the first output with d = 0 is 0.
- R2: With `in_frac` = 0, each output equals exactly the sample accepted one beat before the newest one, on both I and Q.
- R3: Let x0 be the newest accepted I sample, then x1, x2, x3 back in time, and let d = `in_frac`/4096. Each I output equals, within ±1.5 LSB, the cubic Lagrange polynomial through (0,x0), (1,x1), (2,x2), (3,x3) evaluated at delay 1 + d.
- R4: A beat accepted on edge E, with no stall in between, shows `out_valid` high after edge E+2. There is exactly one output per accepted input, in order.
- R5: While `out_valid` is high and `out_ready` is low, `out_i`, `out_q` and `out_valid` hold their values and `in_ready` is low.
- R6: Cycles with `in_valid` low change neither the sample history nor the output stream, whatever `in_i`, `in_q` and `in_frac` carry.
- R7: The result saturates to the range -2048 to 2047 instead of wrapping.
- R8: The Q output obeys the R3 relation on the Q history, computed independently of I but with the same d.
- R9: Each output uses the `in_frac` that arrived with its newest sample, so d may differ on every beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| in_frac | input | 12 | Fractional delay, unsigned, value/4096 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_i | output | 12 | Interpolated in-phase sample, signed |
| out_q | output | 12 | Interpolated quadrature sample, signed |

## Verification
The bench drives d = 0 with extreme samples. There the output must equal the previous sample bit for bit, so a rounding offset or a history misordering shows at once. A four-sample pattern that overshoots full scale on I and undershoots it on Q exposes a design that wraps instead of clamping. Random samples with random d, idle gaps carrying garbage data and random back-pressure catch several faults. A history that shifts on non-transfer cycles gives wrong values. A stall that lets data move gives changed or lost beats. A wrong delay pairing shifts every non-zero-d result away from the Lagrange model. Setting d to 4095 probes the far end of the delay range, where a truncated d product would drift.

// File: rtl/farrow_pkg.sv
package farrow_pkg;
  localparam int NTAPS = 4;
  localparam int NCHAN = 2;

  // Rounded fixed-point value of 1/den with cf fractional bits.
  function automatic int recip_q(input int den, input int cf);
    return ((1 << cf) + den / 2) / den;
  endfunction
endpackage

// File: rtl/farrow_tapline.sv
module farrow_tapline #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
    end
  end
endmodule

// File: rtl/farrow_subfilt.sv
module farrow_subfilt import farrow_pkg::*; #(
  parameter int DW = 12,
  parameter int CF = 12,
  parameter int VW = DW + CF + 3
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  input  logic signed [DW-1:0] x3,
  output logic signed [VW-1:0] v0,
  output logic signed [VW-1:0] v1,
  output logic signed [VW-1:0] v2,
  output logic signed [VW-1:0] v3
);
  localparam logic signed [VW-1:0] K_ONE   = VW'(1 << CF);
  localparam logic signed [VW-1:0] K_HALF  = VW'(recip_q(2, CF));
  localparam logic signed [VW-1:0] K_THIRD = VW'(recip_q(3, CF));
  localparam logic signed [VW-1:0] K_SIXTH = VW'(recip_q(6, CF));

  logic signed [VW-1:0] e0, e1, e2, e3;
  assign e0 = VW'(x0);
  assign e1 = VW'(x1);
  assign e2 = VW'(x2);
  assign e3 = VW'(x3);

  // Cubic Lagrange at delay 1+d, grouped by powers of d (CF fraction bits).
  assign v0 = e1 <<< CF;
  assign v1 = e2 * K_ONE - e0 * K_THIRD - e1 * K_HALF - e3 * K_SIXTH;
  assign v2 = e0 * K_HALF + e2 * K_HALF - e1 * K_ONE;
  assign v3 = e1 * K_HALF - e2 * K_HALF + e3 * K_SIXTH - e0 * K_SIXTH;
endmodule

// File: rtl/farrow_horner.sv
module farrow_horner #(
  parameter int DW = 12,
  parameter int FW = 12,
  parameter int CF = 12,
  parameter int VW = DW + CF + 3
) (
  input  logic signed [VW-1:0] v0,
  input  logic signed [VW-1:0] v1,
  input  logic signed [VW-1:0] v2,
  input  logic signed [VW-1:0] v3,
  input  logic        [FW-1:0] frac,
  output logic signed [DW-1:0] y
);
  localparam int PW = VW + FW + 1;
  localparam logic signed [VW-1:0] RND  = VW'(1 << (CF - 1));
  localparam logic signed [VW-1:0] YMAX = VW'((1 << (DW - 1)) - 1);
  localparam logic signed [VW-1:0] YMIN = -YMAX - VW'(1);

  logic signed [PW-1:0] fe, p3, p2, p1;
  logic signed [VW-1:0] a2, a1, yf, yr;

  always_comb begin
    fe = {{(PW-FW){1'b0}}, frac};
    p3 = PW'(v3) * fe;
    a2 = VW'(p3 >>> FW) + v2;
    p2 = PW'(a2) * fe;
    a1 = VW'(p2 >>> FW) + v1;
    p1 = PW'(a1) * fe;
    yf = VW'(p1 >>> FW) + v0;
    yr = (yf + RND) >>> CF;
    if (yr > YMAX)      y = {1'b0, {(DW-1){1'b1}}};
    else if (yr < YMIN) y = {1'b1, {(DW-1){1'b0}}};
    else                y = DW'(yr);
  end
endmodule

// File: rtl/farrow_interp.sv
module farrow_interp import farrow_pkg::*; #(
  parameter int DATA_W    = 12,
  parameter int FRAC_W    = 12,
  parameter int COEF_FRAC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [FRAC_W-1:0] in_frac,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam int VW = DATA_W + COEF_FRAC + 3;

  logic en, accept;
  logic vld_a, vld_b;
  logic [FRAC_W-1:0] frac_a, frac_b;
  logic [NCHAN*DATA_W-1:0] din_flat, dout_flat;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign accept   = in_valid && en;
  assign din_flat = {in_q, in_i};
  assign out_i    = dout_flat[0 +: DATA_W];
  assign out_q    = dout_flat[DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_a     <= 1'b0;
      vld_b     <= 1'b0;
      out_valid <= 1'b0;
      frac_a    <= '0;
      frac_b    <= '0;
    end else if (en) begin
      vld_a     <= in_valid;
      vld_b     <= vld_a;
      out_valid <= vld_b;
      frac_b    <= frac_a;
      if (in_valid) frac_a <= in_frac;
    end
  end

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    logic [NTAPS-1:0][DATA_W-1:0] taps;
    logic signed [VW-1:0] v0, v1, v2, v3;
    logic signed [VW-1:0] r0, r1, r2, r3;
    logic signed [DATA_W-1:0] y;
    logic [DATA_W-1:0] yq;

    farrow_tapline #(.W(DATA_W), .DEPTH(NTAPS)) u_taps (
      .clk(clk), .rst_n(rst_n), .shift(accept),
      .din(din_flat[ch*DATA_W +: DATA_W]), .taps(taps)
    );

    farrow_subfilt #(.DW(DATA_W), .CF(COEF_FRAC), .VW(VW)) u_sub (
      .x0($signed(taps[0])), .x1($signed(taps[1])),
      .x2($signed(taps[2])), .x3($signed(taps[3])),
      .v0(v0), .v1(v1), .v2(v2), .v3(v3)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r0 <= '0; r1 <= '0; r2 <= '0; r3 <= '0;
      end else if (en) begin
        r0 <= v0; r1 <= v1; r2 <= v2; r3 <= v3;
      end
    end

    farrow_horner #(.DW(DATA_W), .FW(FRAC_W), .CF(COEF_FRAC), .VW(VW)) u_hor (
      .v0(r0), .v1(r1), .v2(r2), .v3(r3), .frac(frac_b), .y(y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  yq <= '0;
      else if (en) yq <= y;
    end

    assign dout_flat[ch*DATA_W +: DATA_W] = yq;
  end
endmodule

// File: rtl/farrow_interp_chk.sv
module farrow_interp_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q
);
  // R1: reset leaves no output beat pending
  a_r1_reset_clears_valid: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R4: accepted beat appears two edges later when nothing stalls
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  // R5: stalled output holds
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  // R5: no input taken while the output is stalled
  a_r5_ready_low_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind farrow_interp farrow_interp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/farrow_interp_tb.sv
module farrow_interp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_i = '0, in_q = '0, in_frac = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [11:0] out_i, out_q;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_mode = 1'b0;
  bit first_item = 1'b1;
  int hist_i [4];
  int hist_q [4];

  typedef struct {
    real ei; real eq;
    int  x1i; int x1q;
    bit  exact; bit clip_i; bit clip_q; bit lat; bit first;
    int  edge_no;
  } exp_t;
  exp_t q_exp[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  farrow_interp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .in_frac(in_frac),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic real lagr(int a0, int a1, int a2, int a3, int f);
    real dd, h0, h1, h2, h3;
    dd = 1.0 + real'(f) / 4096.0;
    h0 = -(dd - 1.0) * (dd - 2.0) * (dd - 3.0) / 6.0;
    h1 = dd * (dd - 2.0) * (dd - 3.0) / 2.0;
    h2 = -dd * (dd - 1.0) * (dd - 3.0) / 2.0;
    h3 = dd * (dd - 1.0) * (dd - 2.0) / 6.0;
    return h0 * real'(a0) + h1 * real'(a1) + h2 * real'(a2) + h3 * real'(a3);
  endfunction

  function automatic real clipr(real y);
    if (y > 2047.0) return 2047.0;
    if (y < -2048.0) return -2048.0;
    return y;
  endfunction

  function automatic real absr(real y);
    return (y < 0.0) ? -y : y;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic send(int vi, int vq, int f);
    exp_t e;
    real ri, rq;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_i = vi[11:0]; in_q = vq[11:0]; in_frac = f[11:0];
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    for (int k = 3; k > 0; k--) begin
      hist_i[k] = hist_i[k-1];
      hist_q[k] = hist_q[k-1];
    end
    hist_i[0] = vi; hist_q[0] = vq;
    ri = lagr(hist_i[0], hist_i[1], hist_i[2], hist_i[3], f);
    rq = lagr(hist_q[0], hist_q[1], hist_q[2], hist_q[3], f);
    e.ei = clipr(ri); e.eq = clipr(rq);
    e.clip_i = (ri > 2047.0) || (ri < -2048.0);
    e.clip_q = (rq > 2047.0) || (rq < -2048.0);
    e.x1i = hist_i[1]; e.x1q = hist_q[1];
    e.exact = (f == 0);
    e.lat = !bp_mode;
    e.first = first_item;
    first_item = 1'b0;
    e.edge_no = cyc + 1;
    q_exp.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_i = 12'($urandom); in_q = 12'($urandom); in_frac = 12'($urandom);
    end
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? ($urandom_range(3) != 0) : 1'b1;
  end

  bit held = 1'b0;
  logic [11:0] hi, hq;

  always @(negedge clk) begin
    if (rst_n) begin
      int ai, aq;
      ai = 32'($signed(out_i));
      aq = 32'($signed(out_q));
      if (held)
        check(out_valid && out_i == hi && out_q == hq, "R5 stalled beat changed",
              ai, 32'($signed(hi)));
      held = out_valid && !out_ready;
      hi = out_i; hq = out_q;
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R6 output with no accepted input", ai, 0);
        end else begin
          exp_t e;
          e = q_exp.pop_front();
          if (e.first) begin
            check(ai == 0, "R1 first output after reset I", ai, 0);
            check(aq == 0, "R1 first output after reset Q", aq, 0);
          end else if (e.exact) begin
            check(ai == e.x1i, "R2 d=0 exact I", ai, e.x1i);
            check(aq == e.x1q, "R2 d=0 exact Q", aq, e.x1q);
          end else begin
            check(absr(real'(ai) - e.ei) <= 1.5,
                  e.clip_i ? "R7 saturate I" : "R3/R9 interpolate I", ai, int'(e.ei));
            check(absr(real'(aq) - e.eq) <= 1.5,
                  e.clip_q ? "R7 saturate Q" : "R8 interpolate Q", aq, int'(e.eq));
          end
          if (e.lat)
            check(cyc == e.edge_no + 2, "R4 latency", cyc, e.edge_no + 2);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // d = 0 directed, including full-scale values
    send(100, -50, 0);
    send(-700, 300, 0);
    send(2047, -2048, 0);
    send(-2048, 2047, 0);
    send(5, 7, 0);
    // overshoot pattern: I clips high, Q clips low
    send(-2048, 2047, 0);
    send(2047, -2048, 0);
    send(2047, -2048, 0);
    send(-2048, 2047, 2048);
    // far end of delay range
    send(1000, -1000, 4095);
    send(-1500, 1800, 1);
    idle(3);

    // random, no back-pressure, with garbage-filled gaps (R6, R9)
    for (int n = 0; n < 300; n++) begin
      send(rnd_s(), rnd_s(), int'($urandom_range(4095)));
      if ($urandom_range(4) == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(6);

    // random with back-pressure (R5)
    bp_mode = 1'b1;
    idle(2);
    for (int n = 0; n < 300; n++) begin
      send(rnd_s(), rnd_s(), ($urandom_range(7) == 0) ? 0 : int'($urandom_range(4095)));
      if ($urandom_range(5) == 0) idle(1);
    end
    idle(1);
    bp_mode = 1'b0;
    for (int n = 0; n < 60 && q_exp.size() != 0; n++) idle(1);
    idle(4);
    check(q_exp.size() == 0, "R4 missing outputs", q_exp.size(), 0);
    summary();
    $finish;
  end
endmodule